// File: doc/BRIEF.md
# Timer Tick Source and Prescaler

This block produces the count-enable for a small modulo timer. It selects one of four tick sources: the bus clock itself, a fixed-frequency strobe, or an external pin counted on either its falling or its rising edge. It then divides the chosen ticks by a power of two between 1 and 256. The result is a one-cycle enable, `cnt_en`, in the bus clock domain, which the downstream counter uses to advance.

An 8-bit configuration register sets the behaviour. Bits 5:4 select the source and bits 3:0 select the prescale code. Bits 7:6 hold no storage and always read as zero. The prescaler is a free-running 8-bit counter that advances on every source tick. Only system reset clears it. A write to the register therefore never restarts the division: the source or the ratio can change while the timer runs, and the next enable comes from the current prescaler state.

The external pin is asynchronous. It passes through a two-flop synchronizer and then a third flop used for edge detection, so each qualifying pin edge gives exactly one source tick. The fixed-frequency strobe is already synchronous and lasts one bus cycle. There is no data stream at this block's edge, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `tmr_tick_gen`

## Requirements
- R1: While reset is asserted and right after it, `cfg_rdata` reads 8'h00, and `cnt_en` is low during reset. After reset the block runs from the bus clock at divide-by-1, so `cnt_en` is high on every cycle starting one cycle after the first clock edge with reset released.
- R2: A write with `cfg_we` high stores `cfg_wdata[5:4]` as the source select and `cfg_wdata[3:0]` as the prescale code. The new value shows on `cfg_rdata` one cycle later. `cfg_rdata[7:6]` always reads 0 whatever was written (8'hFF reads back as 8'h3F).
- R3: Source select 2'b00 gives one source tick on every bus clock cycle.
- R4: Source select 2'b01 gives one source tick for each cycle in which `fix_tick` is high. At divide-by-1, `cnt_en` is high in the cycle after the clock edge that sampled the strobe.
- R5: Source select 2'b10 gives exactly one source tick for each high-to-low transition of `ext_pin`. At divide-by-1, `cnt_en` rises in the third cycle after the edge that first samples the new pin level.
- R6: Source select 2'b11 gives exactly one source tick for each low-to-high transition of `ext_pin`, with the same latency as R5.
- R7: Prescale code k, for k from 0 to 8, produces one `cnt_en` every 2^k source ticks. For k above 0, no two enables fall on consecutive source ticks.
- R8: Prescale codes 9 to 15 behave exactly like code 8, giving divide-by-256.
- R9: A register write does not clear the prescaler. After a change of ratio or source, enables keep following the prescaler count that has built up since reset.
- R10: `cnt_en` is high only in the cycle after a source tick. With a pin source and a pin that does not change, `cnt_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back, bits 7:6 zero |
| fix_tick | input | 1 | Fixed-frequency strobe, synchronous, one cycle wide |
| ext_pin | input | 1 | Asynchronous external tick pin |
| cnt_en | output | 1 | One-cycle count enable for the modulo counter |

## Verification
Each result is due a fixed number of cycles after its stimulus. A register write appears on `cfg_rdata` one cycle after the edge that takes it. An enable from the bus clock or from the strobe appears one cycle after the edge that samples the tick. An enable from the pin appears three cycles after the edge that first samples the new pin level. The bench changes inputs just after each rising edge. It moves a behavioural model forward on that same rising edge, using the values the design has just sampled, and compares `cnt_en` and `cfg_rdata` at the following falling edge, so every due cycle is checked exactly. Window counts of enables then confirm the ratio for each prescale code and the one-tick-per-edge rule for the pin.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    SRC_BUS  = 2'b00,
    SRC_FIX  = 2'b01,
    SRC_FALL = 2'b10,
    SRC_RISE = 2'b11
  } tick_src_e;

  localparam int CFG_W = 8;
  localparam int PSC_W = 4;

  typedef struct packed {
    tick_src_e        src;
    logic [PSC_W-1:0] psc;
  } tick_cfg_t;
endpackage

// File: rtl/tick_cfg_reg.sv
module tick_cfg_reg
  import tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output tick_cfg_t        cfg
);
  localparam int FLD_W = $bits(tick_cfg_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{src: SRC_BUS, psc: '0};
    end else if (we) begin
      cfg <= tick_cfg_t'(wdata[FLD_W-1:0]);
    end
  end

  assign rdata = {{(CFG_W-FLD_W){1'b0}}, cfg};
endmodule

// File: rtl/tick_pin_edge.sv
module tick_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], pin};
  end

  assign rise =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign fall = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             en_out
);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(DIV_W);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic [SEL_W-1:0] sel_sat;
  logic             hit;

  assign sel_sat = (sel > SEL_MAX) ? SEL_MAX : sel;

  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (sel_sat > SEL_W'(i));
  end

  assign hit = &(div_q | ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      en_out <= 1'b0;
    end else begin
      en_out <= src_tick & hit;
      if (src_tick) div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tick_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       fix_tick,
  input  logic       ext_pin,
  output logic       cnt_en
);
  tick_cfg_t cfg;
  logic      pin_rise;
  logic      pin_fall;
  logic      src_tick;

  tick_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  tick_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_pin),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  always_comb begin
    unique case (cfg.src)
      SRC_BUS:  src_tick = 1'b1;
      SRC_FIX:  src_tick = fix_tick;
      SRC_FALL: src_tick = pin_fall;
      SRC_RISE: src_tick = pin_rise;
      default:  src_tick = 1'b0;
    endcase
  end

  tick_prescaler #(.DIV_W(DIV_W), .SEL_W(PSC_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .sel      (cfg.psc),
    .en_out   (cnt_en)
  );
endmodule

// File: rtl/tick_gen_chk.sv
module tick_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       fix_tick,
  input logic       ext_pin,
  input logic       cnt_en
);
  logic [2:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age < 3'd4) age <= age + 3'd1;
  end

  // R2: upper bits never carry storage
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:6] == 2'b00);

  // R3: bus clock at divide-by-1 enables every cycle
  p_bus_every_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && $past(cfg_rdata) == 8'h00) |-> cnt_en);

  // R4: fixed strobe at divide-by-1 maps one to one, one cycle later
  p_fix_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && $past(cfg_rdata) == 8'h10) |-> (cnt_en == $past(fix_tick)));

  // R10: a pin source with a quiet pin gives no enable
  p_quiet_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && $past(cfg_rdata[5]) && ($past(ext_pin, 3) == $past(ext_pin, 4)))
      |-> !cnt_en);

  // R7: with a non-zero code, enables never land on back-to-back cycles
  p_no_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && cnt_en && $past(cfg_rdata[3:0]) != 4'd0
       && $past(cfg_rdata[3:0], 2) != 4'd0) |-> !$past(cnt_en));
endmodule

bind tmr_tick_gen tick_gen_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .fix_tick  (fix_tick),
  .ext_pin   (ext_pin),
  .cnt_en    (cnt_en)
);

// File: tb/tmr_tick_gen_tb_top.sv
`timescale 1ns/1ps
module tmr_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       fix_tick = 1'b0;
  logic       ext_pin = 1'b0;
  logic       cnt_en;

  int checks = 0;
  int errors = 0;
  int en_total = 0;
  int cyc = 0;
  string cur_req = "R1";

  // reference model state
  int m_src = 0, m_ps = 0, m_cnt = 0;
  bit m_en = 0;
  bit h0 = 0, h1 = 0, h2 = 0;

  always #5 clk = ~clk;

  tmr_tick_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .fix_tick  (fix_tick),
    .ext_pin   (ext_pin),
    .cnt_en    (cnt_en)
  );

  // Model advances on the rising edge using the values the design sampled there.
  always @(posedge clk) begin
    bit tick;
    int k, per;
    if (!rst_n) begin
      m_src = 0; m_ps = 0; m_cnt = 0; m_en = 0;
      h0 = 0; h1 = 0; h2 = 0;
    end else begin
      case (m_src)
        0: tick = 1'b1;
        1: tick = fix_tick;
        2: tick = !h1 && h2;
        default: tick = h1 && !h2;
      endcase
      k = (m_ps > 8) ? 8 : m_ps;
      per = 1 << k;
      m_en = tick && ((m_cnt % per) == per - 1);
      if (tick) m_cnt = (m_cnt + 1) % 256;
      if (cfg_we) begin
        m_src = int'(cfg_wdata[5:4]);
        m_ps  = int'(cfg_wdata[3:0]);
      end
      h2 = h1; h1 = h0; h0 = ext_pin;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cnt_en) en_total++;
    chk({cur_req, " cnt_en"}, int'(cnt_en), int'(m_en));
    chk({cur_req, " cfg_rdata"}, int'(cfg_rdata), (m_src << 4) | m_ps);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pin_pulses(int n, int hold);
    for (int i = 0; i < n; i++) begin
      ext_pin = ~ext_pin; step(hold);
      ext_pin = ~ext_pin; step(hold);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    step(4);
    @(negedge clk);
    chk("R1 reset rdata", int'(cfg_rdata), 0);
    chk("R1 reset cnt_en", int'(cnt_en), 0);
    rst_n = 1'b1;
    step(3);
    @(negedge clk);
    chk("R1 bus div1 after reset", int'(cnt_en), 1);

    cur_req = "R2";
    wr(8'hFF);
    @(negedge clk);
    chk("R2 reserved bits read zero", int'(cfg_rdata), 8'h3F);

    // R9: counter mid-phase before changing ratio
    cur_req = "R9";
    wr(8'h00); step(3);
    wr(8'h02); step(20);
    wr(8'h15); step(10);
    wr(8'h03); step(30);

    // R3/R7: each code on the bus clock
    for (int k = 0; k <= 8; k++) begin
      cur_req = "R7";
      wr(8'(k)); step(2);
      @(negedge clk);
      base = en_total;
      repeat (512) @(negedge clk);
      chk("R7 ratio count", en_total - base, 512 >> k);
      if (k == 0) chk("R3 bus every cycle", en_total - base, 512);
    end

    // R8: saturating codes
    for (int k = 9; k <= 15; k++) begin
      cur_req = "R8";
      wr(8'(k)); step(2);
      @(negedge clk);
      base = en_total;
      repeat (512) @(negedge clk);
      chk("R8 high code acts as 256", en_total - base, 2);
    end

    // R4: fixed-frequency strobe
    cur_req = "R4";
    wr(8'h10); step(4);
    base = en_total;
    for (int i = 0; i < 12; i++) begin
      fix_tick = 1'b1; step(1);
      fix_tick = 1'b0; step(i % 4);
    end
    step(3);
    chk("R4 one enable per strobe", en_total - base, 12);
    wr(8'h11); step(2);
    for (int i = 0; i < 9; i++) begin
      fix_tick = (i % 3) != 0; step(1);
    end
    fix_tick = 1'b0; step(4);

    // R5: falling pin edges
    cur_req = "R5";
    ext_pin = 1'b0;
    wr(8'h20); step(6);
    base = en_total;
    pin_pulses(5, 4);
    step(6);
    chk("R5 one enable per falling edge", en_total - base, 5);

    // R10: quiet pin
    cur_req = "R10";
    base = en_total;
    step(20);
    chk("R10 quiet pin gives no enable", en_total - base, 0);

    // R6: rising pin edges, short and long holds
    cur_req = "R6";
    wr(8'h30); step(6);
    base = en_total;
    pin_pulses(4, 1);
    pin_pulses(3, 5);
    step(6);
    chk("R6 one enable per rising edge", en_total - base, 7);

    // R9: source and ratio changes mid-run
    cur_req = "R9";
    wr(8'h31); pin_pulses(6, 2);
    wr(8'h02); step(7);
    wr(8'h21); pin_pulses(5, 3);
    wr(8'h00); step(10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule